// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Output-Float Instruction

This block is a reduced boundary-scan test access port for a memory macro's pad ring. A serial test clock and mode-select line drive the usual sixteen-state controller. Through it, a tester can load a 3-bit instruction and then shift one of three data paths. The paths are a fixed 32-bit identification word, a single-bit bypass stage, and a capture-only boundary register that snapshots a parallel vector taken from the pads.

One instruction is special. While it is the active code, the block raises a signal that tells the functional logic to float its data drivers, so an external tester can drive the data pins. A second capture instruction takes the same snapshot and leaves the drivers alone. Every code that is not defined selects the bypass path, so the serial chain always has a known length. The serial output changes on the falling test-clock edge. Its enable is high only while a shift state is active.

Top module: `scan_tap`

## Requirements
- R1: While `rst_ni` is low, `tdo_o`, `tdo_oe_o` and `hiz_o` are 0. After release, the active instruction is IDCODE (3'b001), so a data-register scan with no prior instruction scan returns the identification word.
- R2: From any controller state, five consecutive rising `tck_i` edges with `tms_i` high reach Test-Logic-Reset. That state restores IDCODE as the active instruction.
- R3: The instruction shift register is loaded with 3'b001 in Capture-IR. The first three `tdo_o` bits of any instruction scan are therefore 1, 0, 0.
- R4: Codes 3'b000, 3'b011, 3'b110, 3'b111 and 3'b101 select the 1-bit bypass stage. It captures 0, so the scan output is 0 followed by `tdi_i` delayed by one bit.
- R5: Under IDCODE, Capture-DR loads {rev[3:0], part[15:0], mfr[10:0], 1'b1}, which is shifted out LSB first. `tdi_i` is not used, so 0s follow bit 31.
- R6: Under 3'b100 (sample) and 3'b010 (sample with float), Capture-DR loads `pad_i`. Bits set in the placeholder mask read 0. The register shifts out LSB first, and `tdi_i` enters at the MSB.
- R7: `hiz_o` is 1 exactly while 3'b010 is the active instruction. Under 3'b100 it is 0.
- R8: A shifted instruction takes effect only on the rising edge that leaves Update-IR. Before that edge, including during Shift-IR, Pause-IR and Update-IR, the previous instruction stays active.
- R9: `tdo_o` and `tdo_oe_o` update on the falling edge of `tck_i`. `tdo_oe_o` is 1 only while the controller is in Shift-IR or Shift-DR.
- R10: `tdi_i` is ignored outside the shift states. Pausing a data scan and toggling `tdi_i` does not alter the shifted contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tms_i | input | 1 | Test mode select, sampled on rising `tck_i` |
| tdi_i | input | 1 | Serial data in, sampled on rising `tck_i` |
| pad_i | input | BS_LEN | Parallel pad-ring vector for boundary capture |
| tdo_o | output | 1 | Serial data out, updated on falling `tck_i` |
| tdo_oe_o | output | 1 | Serial output driver enable |
| hiz_o | output | 1 | Force functional data drivers to high-Z |

## Verification
Each of the eight instruction codes is drawn at random and loaded. A data scan longer than the selected path then follows. The length of the scan, the captured head and the delayed tail of random `tdi_i` show which path was chosen and whether `tdi_i` reached it: the bypass, ID and boundary paths each give a different result. Random pad vectors with placeholder positions that are set show whether the mask is applied at capture. Directed sequences cover a random controller walk ended by five high TMS edges, and an instruction scan parked in Pause-IR, which shows when the float signal changes. They also cover a data scan paused while `tdi_i` toggles, and a sample taken just after a rising edge, which shows that `tdo_o` moves only on the falling edge.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 3;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_FLOAT  = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;

  typedef enum logic [1:0] {PATH_BYPASS, PATH_ID, PATH_BSR} dr_path_e;

  function automatic dr_path_e decode_path(logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE:           return PATH_ID;
      OP_FLOAT, OP_SAMPLE: return PATH_BSR;
      default:             return PATH_BYPASS;
    endcase
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:  state_d = tms_i ? ST_RESET  : ST_IDLE;
      ST_IDLE:   state_d = tms_i ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: state_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms_i ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: state_d = tms_i ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms_i ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms_i ? ST_SEL_DR : ST_IDLE;
      default:   state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] shift_o,
  output logic [IR_W-1:0] active_o
);

  logic [IR_W-1:0] shift_q, active_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q  <= OP_IDCODE;
      active_q <= OP_IDCODE;
    end else begin
      unique case (state_i)
        ST_RESET: begin
          shift_q  <= OP_IDCODE;
          active_q <= OP_IDCODE;
        end
        ST_CAP_IR: shift_q  <= OP_IDCODE;
        ST_SH_IR:  shift_q  <= {tdi_i, shift_q[IR_W-1:1]};
        ST_UPD_IR: active_q <= shift_q;
        default: ;
      endcase
    end
  end

  assign shift_o  = shift_q;
  assign active_o = active_q;

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter int                 BS_LEN       = 70,
  parameter logic [BS_LEN-1:0]  BS_ZERO_MASK = '0,
  parameter logic [ID_W-1:0]    ID_WORD      = 32'h1
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  tap_state_e        state_i,
  input  dr_path_e          path_i,
  input  logic              tdi_i,
  input  logic [BS_LEN-1:0] pad_i,
  output logic              lsb_o
);

  logic [BS_LEN-1:0] cap_vec;
  logic [BS_LEN-1:0] bsr_q;
  logic [ID_W-1:0]   id_q;
  logic              byp_q;

  for (genvar b = 0; b < BS_LEN; b++) begin : g_mask
    assign cap_vec[b] = BS_ZERO_MASK[b] ? 1'b0 : pad_i[b];
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bsr_q <= '0;
      id_q  <= '0;
      byp_q <= 1'b0;
    end else if (state_i == ST_CAP_DR) begin
      unique case (path_i)
        PATH_ID:  id_q  <= ID_WORD;
        PATH_BSR: bsr_q <= cap_vec;
        default:  byp_q <= 1'b0;
      endcase
    end else if (state_i == ST_SH_DR) begin
      unique case (path_i)
        PATH_ID:  id_q  <= {1'b0, id_q[ID_W-1:1]};
        PATH_BSR: bsr_q <= {tdi_i, bsr_q[BS_LEN-1:1]};
        default:  byp_q <= tdi_i;
      endcase
    end
  end

  always_comb begin
    unique case (path_i)
      PATH_ID:  lsb_o = id_q[0];
      PATH_BSR: lsb_o = bsr_q[0];
      default:  lsb_o = byp_q;
    endcase
  end

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int                BS_LEN       = 70,
  parameter logic [BS_LEN-1:0] BS_ZERO_MASK = (BS_LEN'(1) << 36) | (BS_LEN'(1) << 53)
                                             | (BS_LEN'(1) << 54),
  parameter logic [3:0]        ID_REV       = 4'h2,
  parameter logic [15:0]       ID_PART      = 16'h1A5C,
  parameter logic [10:0]       ID_MFR       = 11'h2B6
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tms_i,
  input  logic              tdi_i,
  input  logic [BS_LEN-1:0] pad_i,
  output logic              tdo_o,
  output logic              tdo_oe_o,
  output logic              hiz_o
);

  localparam logic [ID_W-1:0] ID_WORD = {ID_REV, ID_PART, ID_MFR, 1'b1};

  tap_state_e      state;
  logic [IR_W-1:0] ir_shift, ir_active;
  dr_path_e        path;
  logic            dr_lsb;
  logic            tdo_q, oe_q;

  scan_tap_fsm u_fsm (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tms_i   (tms_i),
    .state_o (state)
  );

  scan_tap_ir u_ir (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .state_i  (state),
    .tdi_i    (tdi_i),
    .shift_o  (ir_shift),
    .active_o (ir_active)
  );

  assign path = decode_path(ir_active);

  scan_tap_dr #(
    .BS_LEN       (BS_LEN),
    .BS_ZERO_MASK (BS_ZERO_MASK),
    .ID_WORD      (ID_WORD)
  ) u_dr (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .path_i  (path),
    .tdi_i   (tdi_i),
    .pad_i   (pad_i),
    .lsb_o   (dr_lsb)
  );

  // serial output retimed to the falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= (state == ST_SH_IR) || (state == ST_SH_DR);
      if (state == ST_SH_IR)      tdo_q <= ir_shift[0];
      else if (state == ST_SH_DR) tdo_q <= dr_lsb;
    end
  end

  assign tdo_o    = tdo_q;
  assign tdo_oe_o = oe_q;
  assign hiz_o    = (ir_active == OP_FLOAT);

endmodule

// File: rtl/scan_tap_checker.sv
module scan_tap_checker
  import scan_tap_pkg::*;
(
  input logic            tck_i,
  input logic            rst_ni,
  input logic            tms_i,
  input logic            tdo_oe_o,
  input logic            hiz_o,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_active,
  input logic [IR_W-1:0] ir_shift
);

  logic [2:0] ones_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)         ones_q <= '0;
    else if (!tms_i)     ones_q <= '0;
    else if (ones_q < 5) ones_q <= ones_q + 3'd1;
  end

  p_five_high_reset_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ones_q == 3'd5) |-> (state == ST_RESET));

  p_capture_ir_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state == ST_CAP_IR) |=> (ir_shift == OP_IDCODE));

  p_reset_restores_id_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state == ST_RESET) |=> (ir_active == OP_IDCODE));

  p_ir_only_at_update_r8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ir_active != $past(ir_active)) |->
      ($past(state) == ST_UPD_IR || $past(state) == ST_RESET));

  p_hiz_rise_update_r7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $rose(hiz_o) |-> ($past(state) == ST_UPD_IR));

  p_oe_shift_only_r9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_o == (state == ST_SH_IR || state == ST_SH_DR));

endmodule

bind scan_tap scan_tap_checker u_chk (
  .tck_i     (tck_i),
  .rst_ni    (rst_ni),
  .tms_i     (tms_i),
  .tdo_oe_o  (tdo_oe_o),
  .hiz_o     (hiz_o),
  .state     (state),
  .ir_active (ir_active),
  .ir_shift  (ir_shift)
);

// File: tb/scan_tap_bench.sv
module scan_tap_bench;

  localparam int          BS      = 70;
  localparam logic [BS-1:0] MASK  = (BS'(1) << 36) | (BS'(1) << 53) | (BS'(1) << 54);
  localparam logic [31:0] ID_EXP  = {4'h2, 16'h1A5C, 11'h2B6, 1'b1};

  logic          tck_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tms_i = 1'b1;
  logic          tdi_i = 1'b0;
  logic [BS-1:0] pad_i = '0;
  logic          tdo_o, tdo_oe_o, hiz_o;

  int n_chk = 0;
  int n_fail = 0;
  logic oe_all;

  scan_tap #(
    .BS_LEN(BS), .BS_ZERO_MASK(MASK),
    .ID_REV(4'h2), .ID_PART(16'h1A5C), .ID_MFR(11'h2B6)
  ) u_scan_tap (
    .tck_i(tck_i), .rst_ni(rst_ni), .tms_i(tms_i), .tdi_i(tdi_i),
    .pad_i(pad_i), .tdo_o(tdo_o), .tdo_oe_o(tdo_oe_o), .hiz_o(hiz_o)
  );

  always #10 tck_i = ~tck_i;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // sample what the current state drives, then set inputs for the next rising edge
  task automatic step(input logic tms, input logic tdi, output logic q, output logic oe);
    @(negedge tck_i);
    #2;
    q  = tdo_o;
    oe = tdo_oe_o;
    tms_i = tms;
    tdi_i = tdi;
  endtask

  task automatic scan(input bit is_ir, input int n, input logic [127:0] din,
                      output logic [127:0] dout);
    logic q, oe;
    dout = '0;
    oe_all = 1'b1;
    step(1'b1, 1'b0, q, oe);
    if (is_ir) step(1'b1, 1'b0, q, oe);
    step(1'b0, 1'b0, q, oe);
    step(1'b0, 1'b0, q, oe);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], q, oe);
      dout[i] = q;
      oe_all &= oe;
    end
    step(1'b1, 1'b0, q, oe);
    step(1'b0, 1'b0, q, oe);
  endtask

  function automatic int path_len(input logic [2:0] op);
    case (op)
      3'b001:         return 40;
      3'b010, 3'b100: return BS + 10;
      default:        return 10;
    endcase
  endfunction

  function automatic logic [127:0] exp_dr(input logic [2:0] op, input logic [BS-1:0] pad,
                                          input logic [127:0] din, input int n);
    logic [127:0] v = '0;
    logic [BS-1:0] cap = pad & ~MASK;
    for (int i = 0; i < n; i++) begin
      case (op)
        3'b001:         v[i] = (i < 32) ? ID_EXP[i] : 1'b0;
        3'b010, 3'b100: v[i] = (i < BS) ? cap[i] : din[i-BS];
        default:        v[i] = (i == 0) ? 1'b0 : din[i-1];
      endcase
    end
    return v;
  endfunction

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] din, dout;
    logic q, oe, q0;
    logic [2:0] op;
    void'($urandom(32'd1234));

    repeat (3) @(negedge tck_i);
    chk("R1 reset outputs", {125'b0, tdo_o, tdo_oe_o, hiz_o}, '0);
    #2 rst_ni = 1'b1;
    step(1'b0, 1'b0, q, oe);

    // R1: IDCODE active after reset
    scan(1'b0, 40, '0, dout);
    chk("R1 id after reset", dout, exp_dr(3'b001, '0, '0, 40));
    chk("R9 oe during shift", {127'b0, oe_all}, 128'd1);
    step(1'b0, 1'b0, q, oe);
    chk("R9 oe idle", {127'b0, oe}, '0);

    // R9: tdo moves on falling edge only
    step(1'b1, 1'b0, q, oe);
    step(1'b0, 1'b0, q, oe);
    step(1'b0, 1'b0, q, oe);
    step(1'b0, 1'b0, q0, oe);
    @(posedge tck_i);
    #2;
    chk("R9 tdo held past rising edge", {127'b0, tdo_o}, {127'b0, q0});
    step(1'b1, 1'b0, q, oe);
    chk("R9 tdo next bit after falling edge", {127'b0, q}, {127'b0, ID_EXP[1]});
    step(1'b1, 1'b0, q, oe);
    step(1'b0, 1'b0, q, oe);

    // random instruction / data scans: R3 R4 R5 R6 R7
    for (int it = 0; it < 60; it++) begin
      op = (it < 8) ? it[2:0] : 3'($urandom);
      pad_i = {$urandom, $urandom, $urandom};
      if (it % 5 == 0) pad_i = '1;
      scan(1'b1, 3, {125'b0, op}, dout);
      chk("R3 ir capture", dout, 128'b001);
      step(1'b0, 1'b0, q, oe);
      chk("R7 hiz per op", {127'b0, hiz_o}, {127'b0, op == 3'b010});
      din = {$urandom, $urandom, $urandom, $urandom};
      scan(1'b0, path_len(op), din, dout);
      case (op)
        3'b001:         chk("R5 id shift", dout, exp_dr(op, pad_i, din, path_len(op)));
        3'b010, 3'b100: chk("R6 boundary", dout, exp_dr(op, pad_i, din, path_len(op)));
        default:        chk("R4 bypass", dout, exp_dr(op, pad_i, din, path_len(op)));
      endcase
    end

    // R8: float stays active until Update-IR is left
    scan(1'b1, 3, 128'b010, dout);
    step(1'b0, 1'b0, q, oe);
    chk("R7 float on", {127'b0, hiz_o}, 128'd1);
    step(1'b1, 1'b0, q, oe);
    step(1'b1, 1'b0, q, oe);
    step(1'b0, 1'b0, q, oe);
    step(1'b0, 1'b0, q, oe);
    step(1'b0, 1'b0, q, oe);
    step(1'b0, 1'b0, q, oe);
    step(1'b1, 1'b1, q, oe);
    step(1'b0, 1'b0, q, oe);
    step(1'b0, 1'b0, q, oe);
    chk("R8 pause-ir keeps old op", {127'b0, hiz_o}, 128'd1);
    step(1'b1, 1'b0, q, oe);
    step(1'b1, 1'b0, q, oe);
    step(1'b0, 1'b0, q, oe);
    chk("R8 update-ir keeps old op", {127'b0, hiz_o}, 128'd1);
    step(1'b0, 1'b0, q, oe);
    chk("R8 new sample op active", {127'b0, hiz_o}, '0);

    // R10: tdi ignored while paused
    scan(1'b1, 3, 128'b000, dout);
    step(1'b1, 1'b0, q, oe);
    step(1'b0, 1'b0, q, oe);
    step(1'b0, 1'b0, q, oe);
    step(1'b0, 1'b1, q, oe);
    chk("R4 bypass captures 0", {127'b0, q}, '0);
    step(1'b1, 1'b0, q, oe);
    step(1'b0, 1'b1, q, oe);
    step(1'b0, 1'b1, q, oe);
    step(1'b1, 1'b1, q, oe);
    chk("R9 oe low in pause", {127'b0, oe}, '0);
    step(1'b0, 1'b1, q, oe);
    step(1'b0, 1'b1, q, oe);
    chk("R10 tdi ignored in pause", {127'b0, q}, '0);
    step(1'b1, 1'b0, q, oe);
    step(1'b1, 1'b0, q, oe);
    step(1'b0, 1'b0, q, oe);

    // R2: random walk, then five high TMS edges
    for (int r = 0; r < 4; r++) begin
      scan(1'b1, 3, 128'b010, dout);
      for (int k = 0; k < 12 + r * 5; k++) step(1'($urandom), 1'($urandom), q, oe);
      for (int k = 0; k < 5; k++) step(1'b1, 1'b0, q, oe);
      step(1'b0, 1'b0, q, oe);
      step(1'b0, 1'b0, q, oe);
      chk("R2 float cleared by reset", {127'b0, hiz_o}, '0);
      scan(1'b0, 40, '0, dout);
      chk("R2 id restored", dout, exp_dr(3'b001, '0, '0, 40));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule